// File: doc/BRIEF.md
# Network Controller Command and Status Register Pair

This block is the host-facing control word pair of a network controller. A 16-bit status word gathers interrupt cause flags raised by the controller's internal units, and also shows the live state of the command unit and of the receive unit. A 16-bit command word takes a command for each unit, an interrupt mask bit and a software interrupt request. The block also drives the single interrupt line of the controller.

Software clears cause flags by writing ones to the status word. It issues unit commands by writing the command word. Each nonzero command field is handed to its unit through a valid/ready handshake. The field keeps its value until the unit accepts it, and then reads back as zero. Software therefore polls both fields for zero before it issues the next command. The units themselves, with their descriptor and DMA engines, sit outside the block and are modelled only by their handshake and state inputs.

Top module: `ctl_csr_regs`

## Requirements
- R1: After reset, every cause flag and both command fields are zero and the mask bit is 1. Reading the command word gives 0x0100, and `irq_o` and both `*_cmd_valid` outputs are low.
- R2: A high bit of `evt_i` sets the matching cause flag at the next clock edge. Only flags 15, 14, 13, 12, 11, 10 and 8 exist. Event bits 9 and 7:0 have no effect, and status bits 9, 1 and 0 read as zero.
- R3: A write to the status word (`wr_sel`=0) clears each cause flag whose data bit is 1 and leaves alone each flag whose data bit is 0. It does not change the state fields.
- R4: If an event sets a flag in the same cycle that a status write clears it, the flag stays set.
- R5: Status bits 7:6 show `cu_state_i` and status bits 5:2 show `ru_state_i` in the same cycle the inputs change.
- R6: A command write (`wr_sel`=1) with a legal nonzero code loads that code into an idle field. Command unit codes are in bits 7:4, and the legal values are 1, 2, 4, 5, 6 and 7. Receive unit codes are in bits 2:0, and the legal values are 1, 2, 4, 6 and 7. While a field is nonzero, its `*_cmd_valid` output is high and its `*_cmd_code` output carries the code.
- R7: A field stays unchanged while its ready input is low. It reads back as zero in the cycle after valid and ready are both high.
- R8: A command write to a field that is still nonzero leaves that field unchanged.
- R9: A command write with an illegal code (command unit 3 or 8 to 15, receive unit 3 or 5) leaves the field at zero.
- R10: Every command write loads bit 8 as the mask. `irq_o` is high exactly when some cause flag is set and the mask is 0.
- R11: A command write with bit 9 set sets cause flag 10 at the next edge. Command bit 9 always reads as zero.
- R12: The two command fields are independent. In a single write, one field can load while the other, which is busy, keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status word, 1 command word |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 status word, 1 command word |
| rd_data | output | 16 | Read data of the selected word |
| evt_i | input | 16 | Cause event pulses, one per status bit |
| cu_state_i | input | 2 | Command unit state |
| ru_state_i | input | 4 | Receive unit state |
| cu_cmd_valid | output | 1 | Command unit command pending |
| cu_cmd_code | output | 4 | Pending command unit code |
| cu_cmd_ready | input | 1 | Command unit accepts the pending code |
| ru_cmd_valid | output | 1 | Receive unit command pending |
| ru_cmd_code | output | 3 | Pending receive unit code |
| ru_cmd_ready | input | 1 | Receive unit accepts the pending code |
| irq_o | output | 1 | Interrupt request |

## Verification
The handshake assertions assume that a unit raises its ready only in response to a pending command. They also assume that nothing outside the block changes a field while it is pending. The bench respects both: ready is driven high only in steps where the matching field is known to be busy. The assertions on cause flags assume that events are single-cycle pulses that can coincide with host writes. The stimulus deliberately puts one event in the same cycle as a clear of the same flag, and it drives event bits that have no flag behind them, so that only the implemented flags can respond.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int WORD_W = 16;

  typedef logic [WORD_W-1:0] word_t;

  // Next value of a set of sticky flags: clears first, then sets, then
  // trimmed to the implemented bits (so a set beats a clear).
  function automatic word_t flag_next(word_t cur, word_t set, word_t clr, word_t impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

  // Place a right-aligned field at a given bit position of a word.
  function automatic word_t put_field(word_t val, int unsigned lsb);
    return val << lsb;
  endfunction

endpackage

// File: rtl/csr_cause_bank.sv
module csr_cause_bank
  import csr_pkg::*;
#(
  parameter word_t IMPL = 16'hFD00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_i,
  input  word_t clr_i,
  output word_t flag_o
);

  word_t nxt;

  always_comb nxt = flag_next(flag_o, set_i, clr_i, IMPL);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) flag_o[b] <= 1'b0;
        else        flag_o[b] <= nxt[b];
      end
    end else begin : g_tie
      assign flag_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/csr_cmd_slot.sv
module csr_cmd_slot #(
  parameter int              CODE_W = 4,
  parameter logic [(1<<CODE_W)-1:0] LEGAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              load_o,
  output logic              accept_o
);

  logic [CODE_W-1:0] field_q;
  logic              busy;

  assign busy     = |field_q;
  assign load_o   = wr_i && !busy && (code_i != '0) && LEGAL[code_i];
  assign accept_o = busy && ready_i;
  assign valid_o  = busy;
  assign code_o   = field_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        field_q <= '0;
    else if (load_o)   field_q <= code_i;
    else if (accept_o) field_q <= '0;
  end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_pkg::*;
#(
  parameter int CU_W    = 4,
  parameter int CU_LSB  = 4,
  parameter int RU_W    = 3,
  parameter int RU_LSB  = 0,
  parameter int MASK_BIT = 8,
  parameter int CUS_W   = 2,
  parameter int RUS_W   = 4,
  parameter int RUS_LSB = 2
) (
  input  logic             sel_i,
  input  word_t            flags_i,
  input  logic [CUS_W-1:0] cu_state_i,
  input  logic [RUS_W-1:0] ru_state_i,
  input  logic [CU_W-1:0]  cu_field_i,
  input  logic [RU_W-1:0]  ru_field_i,
  input  logic             mask_i,
  output word_t            data_o
);

  localparam int CUS_LSB = RUS_LSB + RUS_W;

  word_t stat_w;
  word_t cmd_w;

  always_comb begin
    stat_w = flags_i
           | put_field(word_t'(cu_state_i), CUS_LSB)
           | put_field(word_t'(ru_state_i), RUS_LSB);
    cmd_w  = put_field(word_t'(mask_i), MASK_BIT)
           | put_field(word_t'(cu_field_i), CU_LSB)
           | put_field(word_t'(ru_field_i), RU_LSB);
    data_o = sel_i ? cmd_w : stat_w;
  end

endmodule

// File: rtl/ctl_csr_regs.sv
module ctl_csr_regs
  import csr_pkg::*;
#(
  parameter int    CU_W      = 4,
  parameter int    CU_LSB    = 4,
  parameter int    RU_W      = 3,
  parameter int    RU_LSB    = 0,
  parameter int    MASK_BIT  = 8,
  parameter int    SWI_BIT   = 9,
  parameter int    SWI_FLAG  = 10,
  parameter int    CUS_W     = 2,
  parameter int    RUS_W     = 4,
  parameter word_t FLAG_IMPL = 16'hFD00,
  parameter logic [(1<<CU_W)-1:0] CU_LEGAL = 16'h00F6,
  parameter logic [(1<<RU_W)-1:0] RU_LEGAL = 8'hD6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             rd_sel,
  output logic [15:0]      rd_data,
  input  logic [15:0]      evt_i,
  input  logic [CUS_W-1:0] cu_state_i,
  input  logic [RUS_W-1:0] ru_state_i,
  output logic             cu_cmd_valid,
  output logic [CU_W-1:0]  cu_cmd_code,
  input  logic             cu_cmd_ready,
  output logic             ru_cmd_valid,
  output logic [RU_W-1:0]  ru_cmd_code,
  input  logic             ru_cmd_ready,
  output logic             irq_o
);

  localparam int RUS_LSB = 2;

  // Named internal events, visible to the bound checker.
  logic  stat_wr;
  logic  cmd_wr;
  logic  swi_req;
  word_t flag_set;
  word_t flag_clr;
  word_t flag_q;
  logic  mask_q;
  logic  cu_load, cu_accept, ru_load, ru_accept;

  assign stat_wr  = wr_en && !wr_sel;
  assign cmd_wr   = wr_en && wr_sel;
  assign swi_req  = cmd_wr && wr_data[SWI_BIT];
  assign flag_set = (evt_i & FLAG_IMPL) | put_field(word_t'(swi_req), SWI_FLAG);
  assign flag_clr = stat_wr ? (wr_data & FLAG_IMPL) : '0;

  csr_cause_bank #(.IMPL(FLAG_IMPL)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .flag_o(flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= 1'b1;
    else if (cmd_wr) mask_q <= wr_data[MASK_BIT];
  end

  csr_cmd_slot #(.CODE_W(CU_W), .LEGAL(CU_LEGAL)) u_cu_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cmd_wr),
    .code_i  (wr_data[CU_LSB +: CU_W]),
    .ready_i (cu_cmd_ready),
    .valid_o (cu_cmd_valid),
    .code_o  (cu_cmd_code),
    .load_o  (cu_load),
    .accept_o(cu_accept)
  );

  csr_cmd_slot #(.CODE_W(RU_W), .LEGAL(RU_LEGAL)) u_ru_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cmd_wr),
    .code_i  (wr_data[RU_LSB +: RU_W]),
    .ready_i (ru_cmd_ready),
    .valid_o (ru_cmd_valid),
    .code_o  (ru_cmd_code),
    .load_o  (ru_load),
    .accept_o(ru_accept)
  );

  csr_read_mux #(
    .CU_W(CU_W), .CU_LSB(CU_LSB), .RU_W(RU_W), .RU_LSB(RU_LSB),
    .MASK_BIT(MASK_BIT), .CUS_W(CUS_W), .RUS_W(RUS_W), .RUS_LSB(RUS_LSB)
  ) u_rd (
    .sel_i     (rd_sel),
    .flags_i   (flag_q),
    .cu_state_i(cu_state_i),
    .ru_state_i(ru_state_i),
    .cu_field_i(cu_cmd_code),
    .ru_field_i(ru_cmd_code),
    .mask_i    (mask_q),
    .data_o    (rd_data)
  );

  assign irq_o = (|flag_q) && !mask_q;

endmodule

// File: rtl/ctl_csr_regs_chk.sv
module ctl_csr_regs_chk
  import csr_pkg::*;
#(
  parameter int    CU_W      = 4,
  parameter int    RU_W      = 3,
  parameter int    MASK_BIT  = 8,
  parameter int    SWI_BIT   = 9,
  parameter int    SWI_FLAG  = 10,
  parameter word_t FLAG_IMPL = 16'hFD00,
  parameter logic [(1<<CU_W)-1:0] CU_LEGAL = 16'h00F6,
  parameter logic [(1<<RU_W)-1:0] RU_LEGAL = 8'hD6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_sel,
  input logic [15:0]     wr_data,
  input logic [15:0]     evt_i,
  input logic [15:0]     flag_q,
  input logic            cu_cmd_valid,
  input logic [CU_W-1:0] cu_cmd_code,
  input logic            cu_cmd_ready,
  input logic            ru_cmd_valid,
  input logic [RU_W-1:0] ru_cmd_code,
  input logic            ru_cmd_ready,
  input logic            irq_o
);

  // R2, R4: an event leaves its flag set after the edge, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & FLAG_IMPL)) |=>
      ((flag_q & $past(evt_i & FLAG_IMPL)) == $past(evt_i & FLAG_IMPL)));

  // R3: a one written without a coincident event clears the flag
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=>
      ((flag_q & $past(wr_data & ~evt_i & FLAG_IMPL)) == '0));

  // R7: command fields hold while not accepted, clear after acceptance
  a_r7_cu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_cmd_valid && !cu_cmd_ready) |=> (cu_cmd_valid && $stable(cu_cmd_code)));
  a_r7_cu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_cmd_valid && cu_cmd_ready) |=> !cu_cmd_valid);
  a_r7_ru_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_cmd_valid && !ru_cmd_ready) |=> (ru_cmd_valid && $stable(ru_cmd_code)));
  a_r7_ru_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_cmd_valid && ru_cmd_ready) |=> !ru_cmd_valid);

  // R9: only legal codes are ever offered to a unit
  a_r9_cu_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cu_cmd_valid |-> CU_LEGAL[cu_cmd_code]);
  a_r9_ru_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ru_cmd_valid |-> RU_LEGAL[ru_cmd_code]);

  // R10: writing the mask set silences the interrupt
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[MASK_BIT]) |=> !irq_o);

  // R11: software request raises its flag
  a_r11_swi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[SWI_BIT]) |=> flag_q[SWI_FLAG]);

endmodule

bind ctl_csr_regs ctl_csr_regs_chk #(
  .CU_W(CU_W), .RU_W(RU_W), .MASK_BIT(MASK_BIT), .SWI_BIT(SWI_BIT),
  .SWI_FLAG(SWI_FLAG), .FLAG_IMPL(FLAG_IMPL),
  .CU_LEGAL(CU_LEGAL), .RU_LEGAL(RU_LEGAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .evt_i(evt_i), .flag_q(flag_q),
  .cu_cmd_valid(cu_cmd_valid), .cu_cmd_code(cu_cmd_code), .cu_cmd_ready(cu_cmd_ready),
  .ru_cmd_valid(ru_cmd_valid), .ru_cmd_code(ru_cmd_code), .ru_cmd_ready(ru_cmd_ready),
  .irq_o(irq_o)
);

// File: tb/ctl_csr_regs_tb_top.sv
`timescale 1ns/100ps
module ctl_csr_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] evt_i = '0;
  logic [1:0]  cu_state_i = 2'b01;
  logic [3:0]  ru_state_i = 4'h4;
  logic        cu_cmd_valid;
  logic [3:0]  cu_cmd_code;
  logic        cu_cmd_ready = 1'b0;
  logic        ru_cmd_valid;
  logic [2:0]  ru_cmd_code;
  logic        ru_cmd_ready = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_csr_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_i(evt_i),
    .cu_state_i(cu_state_i), .ru_state_i(ru_state_i),
    .cu_cmd_valid(cu_cmd_valid), .cu_cmd_code(cu_cmd_code), .cu_cmd_ready(cu_cmd_ready),
    .ru_cmd_valid(ru_cmd_valid), .ru_cmd_code(ru_cmd_code), .ru_cmd_ready(ru_cmd_ready),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic        wsel;
    logic [15:0] wdata;
    logic [15:0] evt;
    logic        cu_rdy;
    logic        ru_rdy;
    logic [15:0] xstat;
    logic [15:0] xcmd;
    logic        xirq;
    logic [3:0]  req;
  } step_t;

  // State inputs fixed at cu=1, ru=4 during the table: status low byte 0x50.
  localparam step_t TBL [16] = '{
    '{1'b0,1'b0,16'h0000,16'h8000,1'b0,1'b0,16'h8050,16'h0100,1'b0,4'd2},  // R2 set, masked
    '{1'b1,1'b1,16'h0000,16'h0000,1'b0,1'b0,16'h8050,16'h0000,1'b1,4'd10}, // R10 unmask
    '{1'b1,1'b0,16'h0000,16'h0000,1'b0,1'b0,16'h8050,16'h0000,1'b1,4'd3},  // R3 zeros keep
    '{1'b1,1'b0,16'h8000,16'h0000,1'b0,1'b0,16'h0050,16'h0000,1'b0,4'd3},  // R3 one clears
    '{1'b0,1'b0,16'h0000,16'h02FF,1'b0,1'b0,16'h0050,16'h0000,1'b0,4'd2},  // R2 absent bits
    '{1'b0,1'b0,16'h0000,16'h4100,1'b0,1'b0,16'h4150,16'h0000,1'b1,4'd2},  // R2 two flags
    '{1'b1,1'b0,16'h4100,16'h4000,1'b0,1'b0,16'h4050,16'h0000,1'b1,4'd4},  // R4 set wins
    '{1'b1,1'b1,16'h0011,16'h0000,1'b0,1'b0,16'h4050,16'h0011,1'b1,4'd6},  // R6 load both
    '{1'b1,1'b1,16'h0062,16'h0000,1'b0,1'b0,16'h4050,16'h0011,1'b1,4'd8},  // R8 busy ignore
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'h4050,16'h0001,1'b1,4'd7},  // R7 cu accept
    '{1'b1,1'b1,16'h0062,16'h0000,1'b0,1'b0,16'h4050,16'h0061,1'b1,4'd12}, // R12 split load
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b1,16'h4050,16'h0000,1'b1,4'd7},  // R7 both accept
    '{1'b1,1'b1,16'h0035,16'h0000,1'b0,1'b0,16'h4050,16'h0000,1'b1,4'd9},  // R9 illegal codes
    '{1'b1,1'b1,16'h0200,16'h0000,1'b0,1'b0,16'h4450,16'h0000,1'b1,4'd11}, // R11 swi
    '{1'b1,1'b0,16'hFD00,16'h0000,1'b0,1'b0,16'h0050,16'h0000,1'b0,4'd3},  // R3 clear all
    '{1'b1,1'b1,16'h0100,16'h0800,1'b0,1'b0,16'h0850,16'h0100,1'b0,4'd10}  // R10 mask on
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic read_words(output logic [15:0] st, output logic [15:0] cm);
    rd_sel = 1'b0; #0.5; st = rd_data;
    rd_sel = 1'b1; #0.5; cm = rd_data;
  endtask

  // Drive for one edge, then release the inputs just after it.
  task automatic cycle();
    @(posedge clk); #0.5;
    wr_en = 1'b0; wr_data = '0; evt_i = '0; cu_cmd_ready = 1'b0; ru_cmd_ready = 1'b0;
  endtask

  task automatic check_reset(input string tag);
    logic [15:0] st, cm;
    read_words(st, cm);
    chk(st, 16'h0000 | {8'h0, cu_state_i, ru_state_i, 2'b00}, {tag, " status"});
    chk(cm, 16'h0100, {tag, " command"});
    chk({13'h0, irq_o, cu_cmd_valid, ru_cmd_valid}, 16'h0, {tag, " irq/valid"});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] st, cm;
    repeat (3) @(posedge clk);
    #0.5; rst_n = 1'b1;
    check_reset("R1");

    foreach (TBL[i]) begin
      wr_en = TBL[i].wr; wr_sel = TBL[i].wsel; wr_data = TBL[i].wdata;
      evt_i = TBL[i].evt; cu_cmd_ready = TBL[i].cu_rdy; ru_cmd_ready = TBL[i].ru_rdy;
      cycle();
      read_words(st, cm);
      chk(st, TBL[i].xstat, $sformatf("R%0d step%0d status", TBL[i].req, i));
      chk(cm, TBL[i].xcmd, $sformatf("R%0d step%0d command", TBL[i].req, i));
      chk({15'h0, irq_o}, {15'h0, TBL[i].xirq}, $sformatf("R%0d step%0d irq", TBL[i].req, i));
    end

    // R6, R7: handshake outputs carry the code and hold while not ready
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0174; cycle();
    chk({11'h0, cu_cmd_valid, cu_cmd_code}, 16'h0017, "R6 cu valid/code");
    chk({12'h0, ru_cmd_valid, ru_cmd_code}, 16'h000C, "R6 ru valid/code");
    repeat (3) cycle();
    chk({11'h0, cu_cmd_valid, cu_cmd_code}, 16'h0017, "R7 cu held");
    ru_cmd_ready = 1'b1; cycle();
    chk({12'h0, ru_cmd_valid, ru_cmd_code}, 16'h0000, "R7 ru cleared");
    chk({11'h0, cu_cmd_valid, cu_cmd_code}, 16'h0017, "R12 cu unaffected");
    cu_cmd_ready = 1'b1; cycle();
    read_words(st, cm);
    chk(cm, 16'h0100, "R7 cu cleared readback");

    // R5: state fields follow the inputs combinationally
    cu_state_i = 2'b11; ru_state_i = 4'hC; #0.5;
    read_words(st, cm);
    chk(st & 16'h00FF, 16'h00F0, "R5 state fields");
    cu_state_i = 2'b10; ru_state_i = 4'h9; #0.5;
    read_words(st, cm);
    chk(st & 16'h00FF, 16'h00A4, "R5 state fields second");

    // R1: reset in mid-run with pending flags and a pending command
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0010; evt_i = 16'h1000; cycle();
    chk({15'h0, irq_o}, 16'h0001, "R10 irq before reset");
    rst_n = 1'b0; cycle(); cycle();
    check_reset("R1 mid-run");
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule